// File: doc/BRIEF.md
# Legacy-Personality Latch Decoder with Enhanced-Mode Unlock

This block is the legacy host-facing personality of a floppy controller. The host never names a register directly. Every bus access, read or write, carries a latch number and a one-bit value in its address. The access stores that value into one of eight latch flip-flops. Three of those latches then form the index of one of eight logical registers.

Reads in this personality return a fixed pattern. The all-ones register yields 0xFF and every other register yields 0x00.

Writes that land on the mode-set register feed a key detector. The detector looks at bit 6 of the written byte and waits for a four-step pattern. When the pattern is complete, the block raises a one-cycle request to switch the controller to its enhanced register personality. A separate return request from the enhanced side puts the decoder back into its clean legacy state.

Top module: `flp_legacy_decoder`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), `latch_o` is 0x00, `rdata_o` is 0x00, `enh_req_o` is 0 and the key detector is at its first step.
- R2: For an access, address bits [12:10] (the address shifted right by 9, then bits 3..1) select one latch, and address bit 9 is the value stored into it. Latch bit numbering on `latch_o` is: bits 0..3 phase lines, bit 4 motor-on, bit 5 drive-select, bit 6 and bit 7 the two register-select latches. The addressed latch changes and no other latch does, visible on `latch_o` after the same edge.
- R3: A read strobe alone updates the addressed latch exactly as a write strobe does. A cycle with neither strobe leaves every latch unchanged.
- R4: The register index is {latch 7, latch 6, latch 4}, with latch 7 as the MSB. It is taken from the latch contents after the current access has been applied.
- R5: A read whose index is 0 loads 0xFF into `rdata_o` at that edge. A read with any other index loads 0x00. `rdata_o` holds its value while no read occurs.
- R6: A write whose index is 6 advances the key detector when bit 6 of `wdata_i` equals the expected value. The expected values are 1, 0, 1, 1 in order. A mismatching write leaves the detector at its current step.
- R7: The matching write at the fourth step drives `enh_req_o` high for exactly the one cycle after that edge, and returns the detector to its first step.
- R8: Reads of any index, and writes to indices other than 6, never move the key detector.
- R9: `leave_enh_i` clears all latches and the key detector at the next edge. It takes priority over an access in the same cycle: that access changes no latch, does not load `rdata_o`, and cannot raise `enh_req_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| leave_enh_i | input | 1 | Return-to-legacy request; clears latches and key detector |
| addr_i | input | 13 | Byte address; bits [12:9] carry latch number and value |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| latch_o | output | 8 | Current latch vector |
| enh_req_o | output | 1 | One-cycle request to enter the enhanced personality |

## Verification
Two functions can fall in the same cycle: the return-to-legacy clear and a host access. The sharpest case is the fourth, completing key write. The bench drives `leave_enh_i` in the same cycle as that write. It expects no request pulse, an all-zero latch vector and an unchanged read register. It then shows that the detector restarted by requiring a further full four-write pattern before any pulse appears.

// File: rtl/flp_legacy_pkg.sv
package flp_legacy_pkg;

    // latch bit positions on the latch vector
    localparam int LB_PHASE0 = 0;
    localparam int LB_PHASE3 = 3;
    localparam int LB_MOTOR  = 4;
    localparam int LB_DRVSEL = 5;
    localparam int LB_SEL_LO = 6;
    localparam int LB_SEL_HI = 7;

    localparam int N_LATCH  = 8;
    localparam int DATA_W   = 8;
    localparam int ADDR_SHIFT = 9;

    // logical register numbers decoded from {SEL_HI, SEL_LO, MOTOR}
    typedef enum logic [2:0] {
        RG_ALL_ONES = 3'd0,
        RG_RD_DATA  = 3'd1,
        RG_RD_STAT0 = 3'd2,
        RG_RD_STAT1 = 3'd3,
        RG_RD_HSK0  = 3'd4,
        RG_RD_HSK1  = 3'd5,
        RG_MODE_SET = 3'd6,
        RG_WR_DATA  = 3'd7
    } flp_reg_e;

endpackage

// File: rtl/flp_latch_bank.sv
module flp_latch_bank #(
    parameter int N_LATCH = 8,
    localparam int SEL_W = $clog2(N_LATCH)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               clr_i,
    input  logic               acc_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               val_i,
    output logic [N_LATCH-1:0] latch_o,
    output logic [N_LATCH-1:0] latch_nxt_o
);

    typedef struct packed {
        logic [N_LATCH-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.bits = '0;
        end else if (acc_i) begin
            st_d.bits[sel_i] = val_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign latch_o     = st_q.bits;
    assign latch_nxt_o = st_d.bits;

    // addressed latch takes the access value
    assert_addressed_latch_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i && !clr_i) |=> latch_o[$past(sel_i)] == $past(val_i));

    // only the addressed latch may move
    assert_other_latches_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i && !clr_i) |=>
        (((latch_o ^ $past(latch_o)) & ~(N_LATCH'(1) << $past(sel_i))) == '0));

    // idle cycles leave the vector alone
    assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!acc_i && !clr_i) |=> $stable(latch_o));

    // return-to-legacy empties the vector
    assert_clear_latches_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> latch_o == '0);

endmodule

// File: rtl/flp_unlock_seq.sv
module flp_unlock_seq #(
    parameter int          SEQ_LEN = 4,
    parameter logic [3:0]  KEY     = 4'b1101,
    localparam int CNT_W = $clog2(SEQ_LEN)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic step_i,
    input  logic key_bit_i,
    output logic req_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (step_i && (key_bit_i == KEY[st_q.cnt])) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign req_o = st_q.req;

    // the request never lasts two cycles
    assert_req_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o |=> !req_o);

    // a request leaves the detector back at its first step
    assert_req_restarts_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o |-> st_q.cnt == '0);

    // without a mode-set write the detector is frozen
    assert_no_step_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_i && !clr_i) |=> (st_q.cnt == $past(st_q.cnt)) && !req_o);

    // clear resets the detector and suppresses the request
    assert_clear_seq_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (st_q.cnt == '0) && !req_o);

endmodule

// File: rtl/flp_legacy_decoder.sv
module flp_legacy_decoder
    import flp_legacy_pkg::*;
#(
    parameter int SHIFT  = ADDR_SHIFT,
    parameter int DW     = DATA_W,
    parameter int KEYPOS = 6,
    localparam int SEL_W  = $clog2(N_LATCH),
    localparam int ADDR_W = SHIFT + SEL_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              leave_enh_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic [N_LATCH-1:0] latch_o,
    output logic              enh_req_o
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic               acc;
    logic [SEL_W-1:0]   sel;
    logic               val;
    logic [N_LATCH-1:0] latch_nxt;
    flp_reg_e           idx;
    logic               step;

    assign acc = rd_i | wr_i;
    assign sel = addr_i[SHIFT+SEL_W -: SEL_W];
    assign val = addr_i[SHIFT];

    flp_latch_bank #(.N_LATCH(N_LATCH)) u_latch (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clr_i       (leave_enh_i),
        .acc_i       (acc),
        .sel_i       (sel),
        .val_i       (val),
        .latch_o     (latch_o),
        .latch_nxt_o (latch_nxt)
    );

    always_comb begin
        idx  = flp_reg_e'({latch_nxt[LB_SEL_HI], latch_nxt[LB_SEL_LO], latch_nxt[LB_MOTOR]});
        step = wr_i && !leave_enh_i && (idx == RG_MODE_SET);
        rd_d = rd_q;
        if (rd_i && !leave_enh_i) begin
            rd_d.rdata = (idx == RG_ALL_ONES) ? '1 : '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rd_q <= '0;
        else       rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rdata;

    flp_unlock_seq #(.SEQ_LEN(4), .KEY(4'b1101)) u_unlock (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (leave_enh_i),
        .step_i    (step),
        .key_bit_i (wdata_i[KEYPOS]),
        .req_o     (enh_req_o)
    );

    // a read result agrees with the index held in the updated latches
    assert_read_pattern_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !leave_enh_i) |=>
        rdata_o == (({latch_o[LB_SEL_HI], latch_o[LB_SEL_LO], latch_o[LB_MOTOR]} == 3'd0)
                    ? {DW{1'b1}} : {DW{1'b0}}));

    // no read, no change of read data
    assert_read_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rd_i || leave_enh_i) |=> $stable(rdata_o));

    // a request only follows a mode-set write
    assert_req_after_modeset_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        enh_req_o |-> $past(wr_i) && !$past(leave_enh_i) &&
        ({latch_o[LB_SEL_HI], latch_o[LB_SEL_LO], latch_o[LB_MOTOR]} == 3'd6));

endmodule

// File: tb/flp_legacy_decoder_bench.sv
`timescale 1ns/1ps
module flp_legacy_decoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        leave;
    logic [12:0] addr;
    logic        rd, wr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [7:0]  latch;
    logic        req;

    always #4 clk = ~clk;

    flp_legacy_decoder u_flp_legacy_decoder (
        .clk_i(clk), .rst_i(rst), .leave_enh_i(leave), .addr_i(addr),
        .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .latch_o(latch), .enh_req_o(req)
    );

    typedef struct {
        logic [7:0] latch;
        logic [7:0] rdata;
        logic       req;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // reference state built from the requirements
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_rdata = 8'h00;
    int         m_step  = 0;
    logic [3:0] m_key   = 4'b1101; // step0..3 expect 1,0,1,1

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: one access per call, pushes the expected outcome
    task automatic access(input bit r, input bit w, input int sel, input bit v,
                          input logic [7:0] d, input bit lv, input string tag);
        exp_t e;
        logic m_req;
        int   idx;
        @(negedge clk);
        addr  = '0;
        addr[12:10] = sel[2:0];
        addr[9] = v;
        rd = r; wr = w; wdata = d; leave = lv;
        m_req = 1'b0;
        if (lv) begin
            m_latch = 8'h00;
            m_step  = 0;
        end else begin
            if (r || w) m_latch[sel] = v;
            idx = {m_latch[7], m_latch[6], m_latch[4]};
            if (r) m_rdata = (idx == 0) ? 8'hFF : 8'h00;
            if (w && idx == 6 && d[6] == m_key[m_step]) begin
                if (m_step == 3) begin m_step = 0; m_req = 1'b1; end
                else m_step++;
            end
        end
        @(posedge clk);
        #1;
        rd = 0; wr = 0; leave = 0;
        e.latch = m_latch; e.rdata = m_rdata; e.req = m_req; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares each expected item one half-cycle after its edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "latch_o",   latch, e.latch);
            check(e.tag, "rdata_o",   rdata, e.rdata);
            check(e.tag, "enh_req_o", req,   e.req);
        end
    end

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    // mode-set write: L7=1, L6=1, motor=0 keeps index 6; address rewrites L6=1
    task automatic key_wr(input bit b, input string tag);
        access(0, 1, 6, 1, b ? 8'h40 : 8'hBF, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; leave = 0; addr = '0; rd = 0; wr = 0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "latch_o",   latch, 8'h00);
        check("R1", "rdata_o",   rdata, 8'h00);
        check("R1", "enh_req_o", req,   0);

        // R2 R3: walk each latch up with reads and down with writes, idle between
        for (int i = 0; i < 8; i++) access(1, 0, i, 1, 8'h00, 0, "R3_read_sets");
        access(0, 0, 2, 0, 8'h00, 0, "R3_idle");
        for (int i = 0; i < 8; i++) access(0, 1, i, 0, 8'h00, 0, "R2_write_clears");
        access(0, 1, 5, 1, 8'h00, 0, "R2_single");
        access(1, 0, 0, 1, 8'h00, 0, "R2_single");

        // R4 R5: index 0 reads all ones, others zero; hold while idle
        access(1, 0, 3, 1, 8'h00, 0, "R5_idx0");
        access(1, 0, 4, 1, 8'h00, 0, "R4_motor_idx1");
        access(0, 0, 0, 0, 8'h00, 0, "R5_hold");
        access(1, 0, 4, 0, 8'h00, 0, "R4_back_idx0");
        access(1, 0, 7, 1, 8'h00, 0, "R4_idx4");
        access(1, 0, 6, 1, 8'h00, 0, "R4_idx6");
        access(0, 1, 7, 1, 8'hFF, 0, "R5_write_no_load");

        // R6 R8: key with a mismatch, a read of index 6, a write to index 7
        key_wr(1, "R6_step0");
        key_wr(1, "R6_mismatch_hold");
        access(1, 0, 6, 1, 8'h00, 0, "R8_read_idx6");
        access(0, 1, 4, 1, 8'h00, 0, "R8_motor_idx7");
        access(0, 1, 4, 1, 8'h40, 0, "R8_write_idx7");
        access(0, 1, 4, 0, 8'hBF, 0, "R6_step1");
        key_wr(1, "R6_step2");
        key_wr(1, "R7_pulse");
        access(0, 0, 0, 0, 8'h00, 0, "R7_one_cycle");

        // R7 second full pass from restart
        key_wr(1, "R7_again0");
        key_wr(0, "R7_again1");
        key_wr(1, "R7_again2");
        key_wr(1, "R7_again_pulse");

        // R9: clear collides with the completing write
        key_wr(1, "R9_pre0");
        key_wr(0, "R9_pre1");
        key_wr(1, "R9_pre2");
        access(1, 1, 6, 1, 8'h40, 1, "R9_clear_wins");
        access(0, 0, 0, 0, 8'h00, 0, "R9_no_pulse");
        access(0, 1, 7, 1, 8'h00, 0, "R9_setup");
        access(0, 1, 6, 1, 8'h00, 0, "R9_setup");
        key_wr(1, "R9_restart0");
        key_wr(0, "R9_restart1");
        key_wr(1, "R9_restart2");
        key_wr(1, "R9_restart_pulse");

        drain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule